// File: doc/BRIEF.md
# Memory Frequency Switch Sequencer

This block carries out the hardware side of a memory clock frequency change. Software first sets the option bits of a control word: the switch mode, whether the clock acknowledge is skipped, whether the I/O pads are held, and whether timing writes go to a staging copy. It also programs a ready-mask of bus masters and the refresh timing word. It then sets the start bit and polls that bit until the hardware clears it.

Once started, the sequencer waits until every bus master selected in the mask reports idle. It then holds the pads if that option is set, and raises a clock-switch request, waiting for the acknowledge unless bypass is set. If staging is on, it copies the staged refresh timing word into the active copy with a one-cycle load strobe. It then releases the pads and clears start. The clock generator and the memory command logic sit outside this block.

Top module: `fswitch_seq`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0, and `sw_req`, `pad_hold`, `shadow_load` and `sw_mode` are low.
- R2: A control write with bit 0 (start) set launches the sequence. With every input ready and an immediate acknowledge, start reads 0 four clock edges after the writing edge. The pad-hold step adds one edge, the load step adds one edge, and each extra cycle of acknowledge delay adds one edge.
- R3: For master i, mask bit i = 1 makes the sequencer wait for `master_ready[i]`. Mask bit i = 0 treats that master as always ready. The switch request is raised only after all selected masters report ready.
- R4: Control bit 13 (pad hold) makes `pad_hold` high from the hold step through the load step, including the whole time `sw_req` is high. When the bit is clear, `pad_hold` stays low.
- R5: `sw_req` stays high until `sw_ack` is seen, unless control bit 4 (bypass) is set. With bypass, the request lasts one cycle and the acknowledge is not needed.
- R6: `sw_mode` outputs control bit 1: 0 selects dynamic scaling and 1 selects the alternative switch mode.
- R7: When control bit 15 (staging) is set, a timing write changes only the staged copy (address 3) and leaves the active copy (address 2) unchanged. During the sequence, `shadow_load` pulses for one cycle and the active copy takes the staged value.
- R8: When staging is clear, a timing write updates the active copy and the staged copy at the same edge, and no load pulse occurs.
- R9: While start reads 1, control writes are ignored: the control word and `sw_mode` keep their values.
- R10: `refresh_interval` outputs bits [31:16] of the active timing word (refresh interval in units of 32 controller clocks). `refresh_cycles` outputs bits [15:0] (refresh cycle time in controller clocks).
- R11: Address map: 0 is control, 1 is the ready mask, 2 is the active timing word, and 3 is the staged timing word. Only control bits 0, 1, 4, 13 and 15 are stored; the other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| master_ready | input | NUM_MASTERS | Idle indication per bus master |
| sw_ack | input | 1 | Clock switch acknowledge |
| sw_req | output | 1 | Clock switch request |
| sw_mode | output | 1 | Selected switch mode |
| pad_hold | output | 1 | Hold the memory I/O pads |
| shadow_load | output | 1 | One-cycle strobe copying staged timing into active |
| refresh_interval | output | 16 | Active refresh interval field |
| refresh_cycles | output | 16 | Active refresh cycle time field |

## Verification
The assertions assume that software never clears start itself, and that `sw_ack` is only meaningful while `sw_req` is high. They also assume `master_ready` may change at any cycle, so the ready condition is checked only in the cycle before the request or hold rises. The stimulus drives `sw_ack` only in reply to an observed request. It changes `master_ready` and the mask only at negative edges. It issues control writes during a running sequence only in order to check that they are ignored.

// File: rtl/fsw_pkg.sv
// Shared definitions for the frequency switch sequencer: register
// addresses, control bit positions and the sequence state encoding.
package fsw_pkg;
    localparam int ADDR_W     = 2;
    localparam int DATA_W     = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] A_ACTIVE = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAGED = 2'd3;

    localparam int B_START  = 0;
    localparam int B_MODE   = 1;
    localparam int B_BYPASS = 4;
    localparam int B_HOLD   = 13;
    localparam int B_STAGE  = 15;

    localparam logic [DATA_W-1:0] CTRL_KEEP =
        (32'd1 << B_START) | (32'd1 << B_MODE) | (32'd1 << B_BYPASS) |
        (32'd1 << B_HOLD)  | (32'd1 << B_STAGE);

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_HOLD, ST_SWITCH, ST_LOAD, ST_RELEASE
    } seq_state_t;
endpackage

// File: rtl/fsw_ready_gate.sv
// Reduces the per-master ready inputs under the mask into one flag.
// Assumes mask bits above NUM_MASTERS have no master behind them.
module fsw_ready_gate #(
    parameter int NUM_MASTERS = 4
) (
    input  logic [NUM_MASTERS-1:0] ready,
    input  logic [NUM_MASTERS-1:0] mask,
    output logic                   all_ready
);
    logic [NUM_MASTERS-1:0] ok;

    // One term per master: unmasked masters count as ready.
    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_term
        assign ok[i] = ready[i] | ~mask[i];
    end

    assign all_ready = &ok;
endmodule

// File: rtl/fsw_regs.sv
// Register file: control word with self-clearing start, ready mask,
// and active/staged refresh timing words. Assumes done and load come
// from the sequencer and never coincide with a permitted control write.
module fsw_regs
    import fsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              load,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] active_q,
    output logic [DATA_W-1:0] staged_q
);
    logic busy;
    assign busy = ctrl_q[B_START];

    // Control word: written only while idle, start cleared on done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (done)
            ctrl_q[B_START] <= 1'b0;
        else if (wr && addr == A_CTRL && !busy)
            ctrl_q <= wdata & CTRL_KEEP;
    end

    // Ready mask: plain read/write register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr && addr == A_MASK)
            mask_q <= wdata;
    end

    // Timing words: staged always written, active written when not staging or on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            staged_q <= '0;
        end else begin
            if (wr && addr == A_ACTIVE)
                staged_q <= wdata;
            if (load)
                active_q <= staged_q;
            else if (wr && addr == A_ACTIVE && !ctrl_q[B_STAGE])
                active_q <= wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = ctrl_q;
            A_MASK:   rdata = mask_q;
            A_ACTIVE: rdata = active_q;
            default:  rdata = staged_q;
        endcase
    end
endmodule

// File: rtl/fsw_fsm.sv
// Sequence controller: wait for masters, optional pad hold, clock
// switch handshake, optional staged timing load, release. Assumes
// option inputs stay constant while start is set.
module fsw_fsm
    import fsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold_en,
    input  logic stage_en,
    input  logic bypass,
    input  logic all_ready,
    input  logic ack,
    output logic req,
    output logic hold,
    output logic load,
    output logic done
);
    seq_state_t state, nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_WAIT;
            ST_WAIT:    if (all_ready) nxt = hold_en ? ST_HOLD : ST_SWITCH;
            ST_HOLD:    nxt = ST_SWITCH;
            ST_SWITCH:  if (bypass || ack) nxt = stage_en ? ST_LOAD : ST_RELEASE;
            ST_LOAD:    nxt = ST_RELEASE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Output decode.
    assign req  = (state == ST_SWITCH);
    assign load = (state == ST_LOAD);
    assign done = (state == ST_RELEASE);
    assign hold = hold_en && (state == ST_HOLD || state == ST_SWITCH || state == ST_LOAD);
endmodule

// File: rtl/fswitch_seq.sv
// Top of the frequency switch sequencer: joins register file, ready
// gate and sequence controller. Assumes NUM_MASTERS <= 32.
module fswitch_seq
    import fsw_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic [NUM_MASTERS-1:0] master_ready,
    input  logic                   sw_ack,
    output logic                   sw_req,
    output logic                   sw_mode,
    output logic                   pad_hold,
    output logic                   shadow_load,
    output logic [15:0]            refresh_interval,
    output logic [15:0]            refresh_cycles
);
    logic [DATA_W-1:0] ctrl_q, mask_q, active_q, staged_q;
    logic              all_ready, done;

    fsw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .done(done), .load(shadow_load),
        .rdata(reg_rdata), .ctrl_q(ctrl_q), .mask_q(mask_q),
        .active_q(active_q), .staged_q(staged_q)
    );

    fsw_ready_gate #(.NUM_MASTERS(NUM_MASTERS)) u_gate (
        .ready(master_ready), .mask(mask_q[NUM_MASTERS-1:0]),
        .all_ready(all_ready)
    );

    fsw_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(ctrl_q[B_START]),
        .hold_en(ctrl_q[B_HOLD]), .stage_en(ctrl_q[B_STAGE]),
        .bypass(ctrl_q[B_BYPASS]), .all_ready(all_ready), .ack(sw_ack),
        .req(sw_req), .hold(pad_hold), .load(shadow_load), .done(done)
    );

    assign sw_mode          = ctrl_q[B_MODE];
    assign refresh_interval = active_q[31:16];
    assign refresh_cycles   = active_q[15:0];
endmodule

// File: rtl/fswitch_seq_chk.sv
// Property checker for the frequency switch sequencer, bound to the top.
// Assumes the top's internal register words are visible by name.
module fswitch_seq_chk
    import fsw_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_wr,
    input logic [1:0]             reg_addr,
    input logic [NUM_MASTERS-1:0] master_ready,
    input logic                   sw_ack,
    input logic                   sw_req,
    input logic                   pad_hold,
    input logic                   shadow_load,
    input logic [31:0]            ctrl_q,
    input logic [31:0]            mask_q,
    input logic [31:0]            active_q,
    input logic [31:0]            staged_q
);
    logic ready_ok;
    assign ready_ok = ((master_ready | ~mask_q[NUM_MASTERS-1:0]) == '1);

    // R5
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !sw_ack && !ctrl_q[B_BYPASS]) |=> sw_req);

    // R3
    ready_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sw_req) && !ctrl_q[B_HOLD]) |-> $past(ready_ok));

    // R3
    ready_before_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_hold) |-> $past(ready_ok));

    // R4
    hold_only_when_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_hold |-> ctrl_q[B_HOLD]);

    // R7
    load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_load |=> (active_q == $past(staged_q)));

    // R9
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_START] && reg_wr && reg_addr == A_CTRL) |=> $stable(ctrl_q[31:1]));
endmodule

bind fswitch_seq fswitch_seq_chk #(.NUM_MASTERS(NUM_MASTERS)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .master_ready(master_ready), .sw_ack(sw_ack), .sw_req(sw_req),
    .pad_hold(pad_hold), .shadow_load(shadow_load), .ctrl_q(ctrl_q),
    .mask_q(mask_q), .active_q(active_q), .staged_q(staged_q)
);

// File: tb/fswitch_seq_tb_top.sv
// Self-checking bench: sweeps option combinations and mask patterns,
// computing expected completion edges arithmetically.
module fswitch_seq_tb_top;
    localparam int NM = 4;
    localparam int RDY_AT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NM-1:0] master_ready = '1;
    logic          sw_ack = 1'b0;
    logic          sw_req, sw_mode, pad_hold, shadow_load;
    logic [15:0]   refresh_interval, refresh_cycles;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    fswitch_seq #(.NUM_MASTERS(NM)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .master_ready(master_ready), .sw_ack(sw_ack), .sw_req(sw_req),
        .sw_mode(sw_mode), .pad_hold(pad_hold), .shadow_load(shadow_load),
        .refresh_interval(refresh_interval), .refresh_cycles(refresh_cycles)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles > 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a negative edge; returns at the following negative edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd0; #1;
    endtask

    task automatic run_seq(input int seq, input bit mode, input bit h, input bit b,
                           input bit y, input int d, input logic [NM-1:0] mask,
                           input logic [NM-1:0] rdy);
        logic [31:0] tv, old, v;
        int c, reqcnt, loads, expc;
        bit blocked, stop;
        tv = {16'(seq * 7 + 3), 16'(seq * 5 + 1)};
        wr(2'd0, (32'(b) << 15) | (32'(h) << 13) | (32'(y) << 4) | (32'(mode) << 1));
        wr(2'd1, 32'(mask));
        rd(2'd2, old);
        wr(2'd2, tv);
        rd(2'd2, v);
        if (b) chk("R7 active unchanged", v, old);
        else   chk("R8 active direct", v, tv);
        rd(2'd3, v);
        chk("R7/R8 staged copy", v, tv);
        wr(2'd0, (32'(b) << 15) | (32'(h) << 13) | (32'(y) << 4) | (32'(mode) << 1) | 32'd1);
        blocked = (mask & ~rdy) != '0;
        c = 0; reqcnt = 0; loads = 0; stop = 1'b0;
        while (!stop && c < 60) begin
            master_ready = (!blocked || c >= RDY_AT) ? '1 : rdy;
            if (sw_req) begin
                reqcnt++;
                chk("R4 hold during request", 32'(pad_hold), 32'(h));
                chk("R6 mode output", 32'(sw_mode), 32'(mode));
            end
            sw_ack = sw_req && !y && (reqcnt > d);
            if (shadow_load) loads++;
            @(posedge clk); c++; @(negedge clk);
            if (reg_rdata[0] == 1'b0) stop = 1'b1;
        end
        sw_ack = 1'b0; master_ready = '1;
        expc = 4 + h + b + (y ? 0 : d) + (blocked ? (RDY_AT + 1 - 2) : 0);
        chk(blocked ? "R3 masked wait edges" : (y ? "R5 bypass edges" : "R2 completion edges"),
            32'(c), 32'(expc));
        chk("R7 load pulses", 32'(loads), 32'(b));
        chk("R10 interval field", 32'(refresh_interval), 32'(tv[31:16]));
        chk("R10 cycles field", 32'(refresh_cycles), 32'(tv[15:0]));
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset", v, 32'd0);
        end
        chk("R1 outputs reset", {28'd0, sw_req, pad_hold, shadow_load, sw_mode}, 32'd0);

        // R11 stored control bits only
        wr(2'd0, 32'hFFFF_FFFE);
        rd(2'd0, v);
        chk("R11 control bits", v, 32'h0000_A012);
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h1234_5678);
        rd(2'd1, v);
        chk("R11 mask readback", v, 32'h1234_5678);
        wr(2'd1, 32'd0);

        // R9 / R5 directed: withheld acknowledge, writes while busy
        wr(2'd0, 32'd1);
        repeat (5) @(negedge clk);
        chk("R5 request held without ack", 32'(sw_req), 32'd1);
        wr(2'd0, 32'h0000_A012);
        rd(2'd0, v);
        chk("R9 control unchanged while busy", v, 32'd1);
        chk("R9 mode unchanged while busy", 32'(sw_mode), 32'd0);
        chk("R4 no hold when bit clear", 32'(pad_hold), 32'd0);
        sw_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        sw_ack = 1'b0;
        chk("R5 request drops after ack", 32'(sw_req), 32'd0);
        @(posedge clk); @(negedge clk);
        rd(2'd0, v);
        chk("R2 start cleared", v, 32'd0);

        // Sweep of all option combinations
        for (int i = 0; i < 16; i++)
            run_seq(i, i[0], i[1], i[2], i[3], i % 3, 4'hF, 4'hF);
        // Sweep of all mask patterns against a fixed ready pattern
        for (int m = 0; m < 16; m++)
            run_seq(16 + m, 1'b0, m[0], 1'b1, 1'b0, 0, 4'(m), 4'b0101);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule